// File: doc/BRIEF.md
# Virtual Interrupt Preemption Checker

This combinational block decides whether the most urgent pending virtual interrupt may be presented to the processor right now. It takes one pending entry's 8-bit priority and group bit, together with the virtual interface enable, the priority mask and the current running priority. From these it computes a single grant flag. A smaller priority number is more urgent. A running priority of all ones means that nothing is active.

Preemption of an interrupt that is already running is judged on group priority only. The block builds a group-priority mask from a binary-point value and clears the subpriority bits of both priorities before it compares them. Each group has its own binary point. A shared-binary-point control lets group 1 borrow the group-0 value instead. The block also exports the mask, so the surrounding interrupt controller can use it to record active priorities. Choosing which list entry is pending, and decoding register accesses, are left to the caller.

Top module: `vpc_top`

## Requirements
- R1: When `vif_en` is 0, `can_signal` is 0 for every other input value.
- R2: When `pend_prio` is greater than or equal to `prio_mask` (unsigned compare), `can_signal` is 0.
- R3: When `vif_en` is 1, `pend_prio` is below `prio_mask` and `run_prio` equals 8'hFF, `can_signal` is 1.
- R4: `gprio_mask` equals 8'hFF shifted left by (effective binary point + 1) and truncated to 8 bits. A binary point of 0 gives 8'hFE and a binary point of 7 gives 8'h00.
- R5: The effective binary point is `bpr_g0` when `pend_grp1` is 0 (group 0). It is also `bpr_g0` when `pend_grp1` is 1 and `shared_bpr` is 1. It is `bpr_g1` when `pend_grp1` is 1 and `shared_bpr` is 0.
- R6: When `vif_en` is 1, the mask check of R2 passes and `run_prio` is not 8'hFF, `can_signal` is 1 exactly when (`pend_prio` & `gprio_mask`) is strictly less than (`run_prio` & `gprio_mask`). Equal group priorities give 0.
- R7: Changing bits of `pend_prio` or `run_prio` at positions where `gprio_mask` is 0 does not change the R6 preemption result.
- R8: `gprio_mask` depends only on `pend_grp1`, `shared_bpr`, `bpr_g0` and `bpr_g1`. It is unaffected by `vif_en` and by the three priority inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vif_en | input | 1 | Virtual interface enable |
| pend_prio | input | 8 | Priority of the pending entry |
| pend_grp1 | input | 1 | Group of the pending entry (1 = group 1) |
| prio_mask | input | 8 | Priority mask threshold |
| bpr_g0 | input | 3 | Group-0 binary point |
| bpr_g1 | input | 3 | Group-1 binary point |
| shared_bpr | input | 1 | Group 1 uses the group-0 binary point |
| run_prio | input | 8 | Current running priority (8'hFF = idle) |
| can_signal | output | 1 | Pending entry may be signalled |
| gprio_mask | output | 8 | Group-priority mask in use |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same evaluation as the input that exposes it. A wrong binary-point selection or mask shape appears directly on `gprio_mask`. It also shows as a flipped grant on vectors whose two priorities differ only near the group/subpriority boundary. An off-by-one in either compare shows only on vectors where the pending priority equals the mask, or where the masked priorities are equal. The sweep therefore forces those equalities deliberately for every binary-point and group combination.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
   localparam int VPC_PRIO_W = 8;
   localparam int VPC_BPR_W  = 3;

   typedef enum logic {
      VGRP_0 = 1'b0,
      VGRP_1 = 1'b1
   } vgrp_e;
endpackage

// File: rtl/vpc_bpr_select.sv
module vpc_bpr_select
   import vpc_pkg::*;
#(
   parameter int BPR_W = VPC_BPR_W
) (
   input  vgrp_e            grp,
   input  logic             shared,
   input  logic [BPR_W-1:0] bpr0,
   input  logic [BPR_W-1:0] bpr1,
   output logic [BPR_W-1:0] eff_bpr
);
   logic use_g1;

   // group 1 falls back to the group-0 binary point when sharing is on
   assign use_g1  = (grp == VGRP_1) && !shared;
   assign eff_bpr = use_g1 ? bpr1 : bpr0;
endmodule

// File: rtl/vpc_gprio_mask.sv
module vpc_gprio_mask #(
   parameter int PRIO_W      = 8,
   parameter int BPR_W       = 3,
   parameter bit GEN_SHIFTER = 1'b1
) (
   input  logic [BPR_W-1:0]  bpr,
   output logic [PRIO_W-1:0] mask
);
   localparam logic [PRIO_W-1:0] ONES = {PRIO_W{1'b1}};

   generate
      if (GEN_SHIFTER) begin : g_shift
         // two-step shift keeps the result inside PRIO_W bits even at bpr = PRIO_W-1
         logic [PRIO_W-1:0] stage;
         assign stage = ONES << bpr;
         assign mask  = stage << 1;
      end else begin : g_cmp
         // one comparator per bit: bit i survives when i > bpr
         for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
            assign mask[i] = (32'(bpr) < i);
         end
      end
   endgenerate
endmodule

// File: rtl/vpc_priority_gate.sv
module vpc_priority_gate #(
   parameter int PRIO_W = 8
) (
   input  logic              en,
   input  logic [PRIO_W-1:0] pend,
   input  logic [PRIO_W-1:0] pmr,
   input  logic [PRIO_W-1:0] run,
   input  logic [PRIO_W-1:0] mask,
   output logic              grant
);
   localparam logic [PRIO_W-1:0] IDLE = {PRIO_W{1'b1}};

   logic              unmasked;
   logic              idle;
   logic [PRIO_W-1:0] pend_grp;
   logic [PRIO_W-1:0] run_grp;
   logic              preempts;

   assign unmasked = pend < pmr;
   assign idle     = (run == IDLE);
   assign pend_grp = pend & mask;
   assign run_grp  = run & mask;
   assign preempts = pend_grp < run_grp;

   always_comb begin
      grant = 1'b0;
      if (en && unmasked) begin
         grant = idle ? 1'b1 : preempts;
      end
   end
endmodule

// File: rtl/vpc_top.sv
module vpc_top
   import vpc_pkg::*;
#(
   parameter int PRIO_W      = VPC_PRIO_W,
   parameter int BPR_W       = VPC_BPR_W,
   parameter bit GEN_SHIFTER = 1'b1
) (
   input  logic              vif_en,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic              pend_grp1,
   input  logic [PRIO_W-1:0] prio_mask,
   input  logic [BPR_W-1:0]  bpr_g0,
   input  logic [BPR_W-1:0]  bpr_g1,
   input  logic              shared_bpr,
   input  logic [PRIO_W-1:0] run_prio,
   output logic              can_signal,
   output logic [PRIO_W-1:0] gprio_mask
);
   localparam int BPR_SPAN = 1 << BPR_W;

   generate
      if (PRIO_W < 2) begin : g_bad_prio
         $error("vpc_top: PRIO_W must be at least 2");
      end
      if (BPR_SPAN < PRIO_W) begin : g_bad_bpr
         $error("vpc_top: BPR_W too narrow to reach PRIO_W-1");
      end
   endgenerate

   vgrp_e             grp;
   logic [BPR_W-1:0]  eff_bpr;

   assign grp = pend_grp1 ? VGRP_1 : VGRP_0;

   vpc_bpr_select #(.BPR_W(BPR_W)) u_bsel (
      .grp     (grp),
      .shared  (shared_bpr),
      .bpr0    (bpr_g0),
      .bpr1    (bpr_g1),
      .eff_bpr (eff_bpr)
   );

   vpc_gprio_mask #(
      .PRIO_W      (PRIO_W),
      .BPR_W       (BPR_W),
      .GEN_SHIFTER (GEN_SHIFTER)
   ) u_mask (
      .bpr  (eff_bpr),
      .mask (gprio_mask)
   );

   vpc_priority_gate #(.PRIO_W(PRIO_W)) u_gate (
      .en    (vif_en),
      .pend  (pend_prio),
      .pmr   (prio_mask),
      .run   (run_prio),
      .mask  (gprio_mask),
      .grant (can_signal)
   );
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
   parameter int PRIO_W = 8,
   parameter int BPR_W  = 3
) (
   input logic              vif_en,
   input logic [PRIO_W-1:0] pend_prio,
   input logic              pend_grp1,
   input logic [PRIO_W-1:0] prio_mask,
   input logic [BPR_W-1:0]  bpr_g0,
   input logic [BPR_W-1:0]  bpr_g1,
   input logic              shared_bpr,
   input logic [PRIO_W-1:0] run_prio,
   input logic              can_signal,
   input logic [PRIO_W-1:0] gprio_mask
);
   localparam logic [PRIO_W-1:0] IDLE = {PRIO_W{1'b1}};

   logic known;
   assign known = !$isunknown({vif_en, pend_prio, pend_grp1, prio_mask, bpr_g0,
                               bpr_g1, shared_bpr, run_prio, can_signal, gprio_mask});

   always_comb begin
      if (known) begin
         // R1
         p_disabled_quiet_r1: assert (vif_en || !can_signal);
         // R2
         p_masked_quiet_r2: assert (pend_prio < prio_mask || !can_signal);
         // R3
         p_idle_grant_r3: assert (!(vif_en && pend_prio < prio_mask && run_prio == IDLE)
                                  || can_signal);
         // R4: contiguous upper ones, bit 0 never kept
         p_mask_shape_r4: assert (!gprio_mask[0]
                                  && (((gprio_mask << 1) & ~gprio_mask) == '0));
         // R6: a grant over a running interrupt implies a strictly better group priority
         p_grant_order_r6: assert (!(can_signal && run_prio != IDLE)
                                   || ((pend_prio & gprio_mask) < (run_prio & gprio_mask)));
      end
   end
endmodule

bind vpc_top vpc_checker #(.PRIO_W(PRIO_W), .BPR_W(BPR_W)) u_chk (
   .vif_en     (vif_en),
   .pend_prio  (pend_prio),
   .pend_grp1  (pend_grp1),
   .prio_mask  (prio_mask),
   .bpr_g0     (bpr_g0),
   .bpr_g1     (bpr_g1),
   .shared_bpr (shared_bpr),
   .run_prio   (run_prio),
   .can_signal (can_signal),
   .gprio_mask (gprio_mask)
);

// File: tb/vpc_top_tb.sv
module vpc_top_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       vif_en = 1'b0;
   logic [7:0] pend_prio = '0;
   logic       pend_grp1 = 1'b0;
   logic [7:0] prio_mask = '0;
   logic [2:0] bpr_g0 = '0;
   logic [2:0] bpr_g1 = '0;
   logic       shared_bpr = 1'b0;
   logic [7:0] run_prio = '0;
   logic       can_signal;
   logic [7:0] gprio_mask;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   vpc_top u_dut (
      .vif_en     (vif_en),
      .pend_prio  (pend_prio),
      .pend_grp1  (pend_grp1),
      .prio_mask  (prio_mask),
      .bpr_g0     (bpr_g0),
      .bpr_g1     (bpr_g1),
      .shared_bpr (shared_bpr),
      .run_prio   (run_prio),
      .can_signal (can_signal),
      .gprio_mask (gprio_mask)
   );

   function automatic logic [7:0] ref_mask(bit g1, bit sh, int b0, int b1);
      int eb = (g1 && !sh) ? b1 : b0;
      return 8'((32'hFF << (eb + 1)) & 32'hFF);
   endfunction

   function automatic bit ref_can(bit en, logic [7:0] m, int p, int pm, int rp);
      if (!en) return 1'b0;
      if (p >= pm) return 1'b0;
      if (rp == 255) return 1'b1;
      return (p & m) < (rp & m);
   endfunction

   task automatic apply(bit en, bit g1, bit sh, int b0, int b1,
                        int p, int pm, int rp, string tag);
      logic [7:0] em;
      bit         ec;
      string      t;
      @(posedge clk);
      #1;
      vif_en = en; pend_grp1 = g1; shared_bpr = sh;
      bpr_g0 = 3'(b0); bpr_g1 = 3'(b1);
      pend_prio = 8'(p); prio_mask = 8'(pm); run_prio = 8'(rp);
      @(negedge clk);
      em = ref_mask(g1, sh, b0, b1);
      ec = ref_can(en, em, p, pm, rp);
      n_vec++;
      if (tag != "") t = tag;
      else if (!en) t = "R1";
      else if (p >= pm) t = "R2";
      else if (rp == 255) t = "R3";
      else t = "R6";
      if (can_signal !== ec || gprio_mask !== em) begin
         n_bad++;
         if (can_signal !== ec)
            $display("FAIL %s can_signal=%0b expected %0b (p=%02h pm=%02h rp=%02h)",
                     t, can_signal, ec, p, pm, rp);
         if (gprio_mask !== em)
            $display("FAIL %s gprio_mask=%02h expected %02h (g1=%0b sh=%0b b0=%0d b1=%0d)",
                     (g1 ? "R5" : "R4"), gprio_mask, em, g1, sh, b0, b1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog R1..: run still busy, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // idle state: all inputs zero -> no grant, mask from bpr 0 (R1, R4)
      apply(0, 0, 0, 0, 0, 0, 0, 0, "R1");
      // R4 end points
      apply(1, 0, 0, 0, 0, 8'h10, 8'hFF, 8'hFF, "R4");
      apply(1, 0, 0, 7, 0, 8'h10, 8'hFF, 8'hFF, "R4");
      // R2 boundary: equal to mask is masked
      apply(1, 0, 0, 0, 0, 8'h40, 8'h40, 8'hFF, "R2");
      apply(1, 0, 0, 0, 0, 8'h3F, 8'h40, 8'hFF, "R3");
      // R5: group 1 with and without sharing
      apply(1, 1, 1, 2, 6, 8'h20, 8'hFF, 8'h40, "R5");
      apply(1, 1, 0, 2, 6, 8'h20, 8'hFF, 8'h40, "R5");
      // R7: subpriority bits (mask bits [7:3] at bpr 2) do not matter
      apply(1, 0, 0, 2, 0, 8'h20, 8'hFF, 8'h40, "R7");
      apply(1, 0, 0, 2, 0, 8'h27, 8'hFF, 8'h41, "R7");
      apply(1, 0, 0, 2, 0, 8'h20, 8'hFF, 8'h27, "R7");
      // R8: mask unaffected by enable and priorities
      apply(0, 1, 0, 1, 4, 8'hFF, 8'h00, 8'h00, "R8");
      apply(1, 1, 0, 1, 4, 8'h01, 8'hFF, 8'h80, "R8");

      // full sweep of the configuration space with forced corner priorities
      for (int en = 0; en < 2; en++)
         for (int g1 = 0; g1 < 2; g1++)
            for (int sh = 0; sh < 2; sh++)
               for (int b0 = 0; b0 < 8; b0++)
                  for (int b1 = 0; b1 < 8; b1++)
                     for (int k = 0; k < 8; k++) begin
                        logic [7:0] m = ref_mask(g1[0], sh[0], b0, b1);
                        int p  = int'($urandom_range(0, 255));
                        int pm = (k == 0) ? p : (k >= 3 ? 255 : int'($urandom_range(0, 255)));
                        int rp;
                        if (k == 1) rp = 255;
                        else if (k == 2) rp = int'((8'(p) & m) | (~m & 8'($urandom)));
                        else rp = int'($urandom_range(0, 255));
                        apply(en[0], g1[0], sh[0], b0, b1, p, pm, rp, "");
                     end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule